// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. A lookup request supplies a virtual address, the identifier of the address space that is running, and the kind of access (read, write or instruction fetch). The block compares the page-number part of the address with every stored entry at once. One cycle later it reports whether a translation was found, whether the access breaks that entry's permissions, and, for a permitted hit, the physical address. The physical address is the stored frame number joined to the untouched page offset.

Each entry carries the address-space identifier of the process that owns it. Translations from several processes can therefore stay resident together, and a context switch needs no flush. After a miss, the surrounding logic walks the page table in memory and writes the result through the fill port. Placement of a fill is fixed: an entry that already holds the same page and identifier is reused first. Failing that, the lowest-numbered empty entry is used. Failing that, a round-robin pointer picks the entry to overwrite. The flush port invalidates every entry, or only the entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is empty, so any lookup misses. All response outputs are 0 until the first lookup response.
- R2: A lookup request sampled at a clock edge produces `rsp_valid`=1 in the cycle that follows, and only then. In a cycle that follows no request, `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all 0.
- R3: A hit requires an entry that is valid and whose page number and identifier both equal the request's. Any other lookup is a miss, with `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0.
- R4: On a permitted hit, `rsp_paddr` is the entry's 20-bit frame number in bits 31:12, joined to the request's address bits 11:0 unchanged.
- R5: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Access kinds are 0 read, 1 write, 2 fetch and 3 read. A hit whose kind lacks its permission gives `rsp_hit`=1, `rsp_fault`=1 and `rsp_paddr`=0.
- R6: A fill that is not blocked goes to the entry already holding its page and identifier, if there is one. Otherwise it goes to the lowest-numbered invalid entry. Otherwise it goes to the entry named by a round-robin pointer, which resets to 0 and advances by one, wrapping after entry 7, on each such overwrite only.
- R7: `flush_all` invalidates every entry at the clock edge.
- R8: `flush_asid_en` invalidates exactly the entries whose identifier equals `flush_asid`. Entries of other identifiers stay valid and unchanged.
- R9: In a cycle with either flush request, a fill request is dropped.
- R10: A lookup in the same cycle as a fill or flush is answered from the contents held before that clock edge.
- R11: No two valid entries ever hold the same page and identifier, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Identifier of the running address space |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_asid | input | 8 | Identifier to store |
| fill_pfn | input | 20 | Physical frame number to store |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Permission fault on a found translation |
| rsp_paddr | output | 32 | Physical address; 0 on a miss or a fault |

## Verification
The assertions assume that every input has a defined value in each cycle after reset, and that a lookup is a single-cycle sample that is never held across edges. The stimulus drives all inputs on the falling edge. It draws page numbers from a pool of twelve and identifiers from a pool of three, so repeat fills, full-cache evictions, identifier mismatches and flushes that race a fill or a lookup come up often, while every input value stays in its legal range.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  // Permission check for one access kind; reserved kind behaves as a read.
  function automatic logic perm_allows(logic [PERM_W-1:0] perm, logic [1:0] kind);
    case (acc_kind_e'(kind))
      ACC_WRITE: return perm[PERM_WR];
      ACC_FETCH: return perm[PERM_EX];
      default:   return perm[PERM_RD];
    endcase
  endfunction

endpackage

// File: rtl/asid_tlb_entries.sv
module asid_tlb_entries #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int PRM_W   = 3,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic [PRM_W-1:0]   wr_perm,
  input  logic               clr_all,
  input  logic               clr_asid_en,
  input  logic [ASID_W-1:0]  clr_asid,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] wr_match,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [PRM_W-1:0]   lk_perm
);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [PRM_W-1:0]  perm_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic clr_e;
    logic wr_e;
    assign clr_e = clr_all | (clr_asid_en & (asid_q[i] == clr_asid));
    assign wr_e  = wr_en & (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
        vpn_q[i]     <= '0;
        asid_q[i]    <= '0;
        pfn_q[i]     <= '0;
        perm_q[i]    <= '0;
      end else if (clr_e) begin
        valid_vec[i] <= 1'b0;
      end else if (wr_e) begin
        valid_vec[i] <= 1'b1;
        vpn_q[i]     <= wr_vpn;
        asid_q[i]    <= wr_asid;
        pfn_q[i]     <= wr_pfn;
        perm_q[i]    <= wr_perm;
      end
    end

    assign lk_match[i] = valid_vec[i] & (vpn_q[i] == lk_vpn) & (asid_q[i] == lk_asid);
    assign wr_match[i] = valid_vec[i] & (vpn_q[i] == wr_vpn) & (asid_q[i] == wr_asid);

    // R8: an entry owned by the flushed identifier is empty afterwards
    assert_asid_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_asid_en && valid_vec[i] && asid_q[i] == clr_asid) |=> !valid_vec[i]);
  end

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn  | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(wr_match));

  assert_flush_all_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_vec == '0));

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] tag_match,
  input  logic               commit,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic             any_match;
  logic             all_full;
  logic             replace;

  assign any_match = |tag_match;
  assign all_full  = &valid_vec;
  assign replace   = commit & ~any_match & all_full;

  always_comb begin
    victim_idx = rr_q;
    if (any_match) begin
      for (int i = 0; i < ENTRIES; i++)
        if (tag_match[i]) victim_idx = IDX_W'(i);
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!valid_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (replace) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  assert_fill_uses_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !any_match && !all_full) |-> !valid_vec[victim_idx]);

  assert_fill_reuses_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && any_match) |-> tag_match[victim_idx]);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int OFF_W   = 12,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [1:0]             lk_kind,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [PERM_W-1:0]      fill_perm,
  input  logic                   flush_all,
  input  logic                   flush_asid_en,
  input  logic [ASID_W-1:0]      flush_asid,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr
);

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [PA_W-1:0] join_paddr(logic [PFN_W-1:0] pfn, logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  logic [ENTRIES-1:0] lk_match, wr_match, valid_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [PERM_W-1:0]  hit_perm;
  logic [IDX_W-1:0]   victim_idx;
  logic               flush_any, fill_commit, lk_hit_w, lk_fault_w;

  assign flush_any   = flush_all | flush_asid_en;
  assign fill_commit = fill_valid & ~flush_any;

  asid_tlb_entries #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W),
    .PRM_W(PERM_W), .IDX_W(IDX_W)
  ) u_entries (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_commit), .wr_idx(victim_idx), .wr_vpn(fill_vpn),
    .wr_asid(fill_asid), .wr_pfn(fill_pfn), .wr_perm(fill_perm),
    .clr_all(flush_all), .clr_asid_en(flush_asid_en), .clr_asid(flush_asid),
    .lk_vpn(lk_vaddr[VA_W-1:OFF_W]), .lk_asid(lk_asid),
    .lk_match(lk_match), .wr_match(wr_match), .valid_vec(valid_vec),
    .lk_pfn(hit_pfn), .lk_perm(hit_perm)
  );

  asid_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .tag_match(wr_match),
    .commit(fill_commit), .victim_idx(victim_idx)
  );

  assign lk_hit_w   = |lk_match;
  assign lk_fault_w = lk_hit_w & ~perm_allows(hit_perm, lk_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & lk_hit_w;
      rsp_fault <= lk_valid & lk_fault_w;
      rsp_paddr <= (lk_valid && lk_hit_w && !lk_fault_w)
                   ? join_paddr(hit_pfn, lk_vaddr[OFF_W-1:0]) : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault && rsp_paddr == '0));

  assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_paddr == '0));

  assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit_w && !lk_fault_w) |=> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  assert_flush_beats_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_valid) |=> (valid_vec == '0));

endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic [1:0]  lk_kind;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [19:0] fill_pfn;
  logic [2:0]  fill_perm;
  logic        flush_all;
  logic        flush_asid_en;
  logic [7:0]  flush_asid;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;

  always #10 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_kind(lk_kind), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid(flush_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int fails  = 0;

  bit        m_v    [N];
  bit [19:0] m_vpn  [N];
  bit [7:0]  m_asid [N];
  bit [19:0] m_pfn  [N];
  bit [2:0]  m_perm [N];
  int        m_rr;

  function automatic bit kind_ok(bit [2:0] perm, bit [1:0] kind);
    if (kind == 2'd1) return perm[1];
    if (kind == 2'd2) return perm[2];
    return perm[0];
  endfunction

  task automatic compare(string tag, bit ev, bit eh, bit ef, bit [31:0] ep);
    checks++;
    if (rsp_valid !== ev || rsp_hit !== eh || rsp_fault !== ef || rsp_paddr !== ep) begin
      fails++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b pa=%h, expected v=%0b h=%0b f=%0b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, ev, eh, ef, ep);
    end
  endtask

  task automatic model_update(bit fv, bit [19:0] fvpn, bit [7:0] fas, bit [19:0] fpfn,
                              bit [2:0] fperm, bit fa, bit fae, bit [7:0] fsid);
    int slot;
    if (fa || fae) begin
      for (int i = 0; i < N; i++)
        if (fa || m_asid[i] == fsid) m_v[i] = 1'b0;
    end else if (fv) begin
      slot = -1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == fvpn && m_asid[i] == fas) slot = i;
      if (slot < 0)
        for (int i = N - 1; i >= 0; i--)
          if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1'b1; m_vpn[slot] = fvpn; m_asid[slot] = fas;
      m_pfn[slot] = fpfn; m_perm[slot] = fperm;
    end
  endtask

  task automatic step(bit lv, bit [31:0] va, bit [7:0] la, bit [1:0] lk,
                      bit fv, bit [19:0] fvpn, bit [7:0] fas, bit [19:0] fpfn, bit [2:0] fperm,
                      bit fa, bit fae, bit [7:0] fsid, string tag);
    bit eh, ef;
    bit [31:0] ep;
    lk_valid = lv; lk_vaddr = va; lk_asid = la; lk_kind = lk;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fas; fill_pfn = fpfn; fill_perm = fperm;
    flush_all = fa; flush_asid_en = fae; flush_asid = fsid;
    eh = 1'b0; ef = 1'b0; ep = '0;
    if (lv)
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == va[31:12] && m_asid[i] == la) begin
          eh = 1'b1;
          ef = !kind_ok(m_perm[i], lk);
          ep = ef ? 32'd0 : {m_pfn[i], va[11:0]};
        end
    @(posedge clk);
    model_update(fv, fvpn, fas, fpfn, fperm, fa, fae, fsid);
    @(negedge clk);
    compare(tag, lv, eh, ef, ep);
  endtask

  task automatic lookup(bit [31:0] va, bit [7:0] la, bit [1:0] lk, string tag);
    step(1'b1, va, la, lk, 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic fill(bit [19:0] vpn, bit [7:0] as, bit [19:0] pfn, bit [2:0] perm, string tag);
    step(1'b0, 0, 0, 0, 1'b1, vpn, as, pfn, perm, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no end of run, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7219));
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = 0; lk_asid = 0; lk_kind = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0; fill_perm = 0;
    flush_all = 0; flush_asid_en = 0; flush_asid = 0;
    repeat (3) @(negedge clk);
    compare("R1", 1'b0, 1'b0, 1'b0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    lookup(32'h1234_5678, 8'd1, 2'd0, "R1");
    fill(20'h00012, 8'd1, 20'hABCDE, 3'b011, "R2");
    lookup(32'h0001_2345, 8'd1, 2'd0, "R4");
    lookup(32'h0001_2FFF, 8'd2, 2'd0, "R3");
    lookup(32'h0001_2001, 8'd1, 2'd1, "R5");
    fill(20'h00013, 8'd1, 20'h00777, 3'b001, "R2");
    lookup(32'h0001_3010, 8'd1, 2'd1, "R5");
    lookup(32'h0001_3010, 8'd1, 2'd2, "R5");
    lookup(32'h0001_3abc, 8'd1, 2'd3, "R5");

    // R10: a lookup racing the fill of its own page still misses
    step(1'b1, 32'h0002_0004, 8'd3, 2'd0, 1'b1, 20'h00020, 8'd3, 20'h55555, 3'b111,
         1'b0, 1'b0, 0, "R10");
    lookup(32'h0002_0004, 8'd3, 2'd2, "R10");

    // R6: fill all entries, then overwrite in round-robin order
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0, "R2");
    for (int i = 0; i < N; i++) fill(20'h00100 + i, 8'd5, 20'h10000 + i, 3'b001, "R6");
    fill(20'h00200, 8'd5, 20'h20000, 3'b001, "R6");
    lookup(32'h0010_0000, 8'd5, 2'd0, "R6");
    lookup(32'h0010_1000, 8'd5, 2'd0, "R6");
    fill(20'h00201, 8'd5, 20'h20001, 3'b001, "R6");
    lookup(32'h0010_1000, 8'd5, 2'd0, "R6");

    // R11: refilling a resident tag updates it in place
    fill(20'h00102, 8'd5, 20'h3BEEF, 3'b001, "R11");
    lookup(32'h0010_2123, 8'd5, 2'd0, "R11");
    lookup(32'h0010_3123, 8'd5, 2'd0, "R11");

    // R8: per-identifier flush
    fill(20'h00300, 8'd6, 20'h0C0DE, 3'b101, "R8");
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 8'd5, "R8");
    lookup(32'h0030_0456, 8'd6, 2'd2, "R8");
    lookup(32'h0010_3123, 8'd5, 2'd0, "R8");

    // R9: flush with a simultaneous fill drops the fill
    step(1'b0, 0, 0, 0, 1'b1, 20'h00400, 8'd6, 20'h44444, 3'b111, 1'b0, 1'b1, 8'd9, "R9");
    lookup(32'h0040_0000, 8'd6, 2'd0, "R9");
    step(1'b0, 0, 0, 0, 1'b1, 20'h00401, 8'd6, 20'h44445, 3'b111, 1'b1, 1'b0, 0, "R7");
    lookup(32'h0030_0456, 8'd6, 2'd2, "R7");
    lookup(32'h0040_1000, 8'd6, 2'd0, "R9");

    for (int n = 0; n < 4000; n++) begin
      bit lv, fv, fa, fae;
      bit [31:0] va;
      lv  = ($urandom % 4) != 0;
      fv  = ($urandom % 3) == 0;
      fa  = ($urandom % 64) == 0;
      fae = ($urandom % 32) == 0;
      va  = {20'h00500 + 20'($urandom % 12), 12'($urandom)};
      step(lv, va, 8'($urandom % 3), 2'($urandom), fv, 20'h00500 + 20'($urandom % 12),
           8'($urandom % 3), 20'($urandom), 3'($urandom), fa, fae, 8'($urandom % 3), "R3");
    end

    summary();
    $finish;
  end

endmodule